// File: doc/BRIEF.md
# Hermitian Frame Builder for a Real-Output Inverse FFT

This block sits in front of an N-point inverse FFT in a multitone transmitter. It accepts the complex constellation points of one multitone symbol, one per tone, and produces the full set of N frequency bins. The spectrum it produces is conjugate-symmetric, so the inverse transform that follows yields N purely real time samples.

The tones are written into a half-size store as they arrive. The output side walks the bins from 0 up to N-1. The lower half is read directly. The upper half is read back in mirrored order with the imaginary part negated. The DC bin and the Nyquist bin are forced to zero. Two stores alternate, so the next symbol can be loaded while the previous one is still being read out. Both edges use a valid/ready handshake, and the output marks the final bin of each symbol.

Top module: `herm_frame_builder`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: Output bin 0 and output bin N/2 are always 0 in both the real and the imaginary part.
- R3: For 1 <= k <= N/2-1, output bin k equals the k-th accepted subsymbol of the same symbol. Subsymbols are counted from 1 in arrival order.
- R4: For 1 <= k <= N/2-1, output bin N-k has the same real part as bin k and the two's-complement negation of its imaginary part.
- R5: When the imaginary part of bin k is the most negative code (0x8000 at 16 bits), bin N-k carries the most positive code (0x7FFF).
- R6: Bins leave in order 0, 1, …, N-1. `out_last_o` is 1 on bin N-1 and 0 on every other bin.
- R7: `out_valid_o` becomes 1 in the cycle after the clock edge that accepts a symbol's final subsymbol, provided no earlier symbol is still waiting or being read.
- R8: With one complete symbol held, `in_ready_o` stays 1. With two complete symbols held, `in_ready_o` is 0. `in_ready_o` returns to 1 in the cycle after the final bin of a symbol is handed off.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the output bin and its data hold steady. Under stalls on either side, no subsymbol is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Subsymbol present |
| in_ready_o | output | 1 | Block can take a subsymbol |
| in_re_i | input | DATA_W | Subsymbol real part, signed |
| in_im_i | input | DATA_W | Subsymbol imaginary part, signed |
| out_valid_o | output | 1 | Bin present |
| out_ready_i | input | 1 | Consumer takes the bin |
| out_re_o | output | DATA_W | Bin real part, signed |
| out_im_o | output | DATA_W | Bin imaginary part, signed |
| out_last_o | output | 1 | Marks bin N-1 |

## Verification
A subsymbol is stored at the clock edge that completes its handshake. The edge that takes the final subsymbol of a symbol raises `out_valid_o`, so bin 0 can be read in the following cycle. Each bin stays on the outputs until the edge that completes its output handshake, and `in_ready_o` rises one edge after the final bin is taken. The bench drives and samples only on falling edges. It advances its expected bin index only after a rising edge on which both valid and ready were seen high. As a result, every comparison lands in the cycle where the result is due, and a stalled bin is compared again for each cycle it is held.

// File: rtl/herm_pkg.sv
package herm_pkg;
  localparam int DATA_W = 16;
  typedef logic signed [DATA_W-1:0] samp_t;
  typedef struct packed {
    samp_t re;
    samp_t im;
  } cplx_t;
endpackage

// File: rtl/herm_conj.sv
module herm_conj
  import herm_pkg::*;
(
  input  cplx_t a_i,
  output cplx_t y_o
);
  localparam samp_t MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam samp_t MAX_V = ~MIN_V;

  always_comb begin
    y_o.re = a_i.re;
    y_o.im = (a_i.im == MIN_V) ? MAX_V : -a_i.im;  // saturate the one code with no positive twin
  end
endmodule

// File: rtl/herm_bank_store.sv
module herm_bank_store
  import herm_pkg::*;
#(
  parameter int DEPTH = 255,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  cplx_t         wdata_i,
  input  logic          rbank_i,
  input  logic [AW-1:0] raddr_i,
  output cplx_t         rdata_o
);
  cplx_t rd_b [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    cplx_t mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wbank_i == 1'(b))) mem[waddr_i] <= wdata_i;
    end
    assign rd_b[b] = mem[raddr_i];
  end

  assign rdata_o = rd_b[rbank_i];
endmodule

// File: rtl/herm_bin_seq.sv
module herm_bin_seq #(
  parameter int N_PTS = 512,
  localparam int HALF = N_PTS / 2,
  localparam int BW   = $clog2(N_PTS),
  localparam int TW   = $clog2(HALF - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic          last_o,
  output logic          zero_o,
  output logic          mirror_o,
  output logic [TW-1:0] addr_o,
  output logic          wrap_o
);
  logic [BW-1:0] bin_q;

  always_comb begin
    last_o   = (bin_q == BW'(N_PTS - 1));
    zero_o   = (bin_q == '0) || (bin_q == BW'(HALF));
    mirror_o = (bin_q > BW'(HALF));
    if (zero_o)        addr_o = '0;
    else if (mirror_o) addr_o = TW'(N_PTS - 1 - int'(bin_q));  // bin N-k reads tone k
    else               addr_o = TW'(int'(bin_q) - 1);
    wrap_o   = adv_i && last_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bin_q <= '0;
    else if (adv_i)  bin_q <= last_o ? '0 : bin_q + 1'b1;
  end
endmodule

// File: rtl/herm_frame_builder.sv
module herm_frame_builder
  import herm_pkg::*;
#(
  parameter int N_PTS = 512
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic signed [DATA_W-1:0] in_re_i,
  input  logic signed [DATA_W-1:0] in_im_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic signed [DATA_W-1:0] out_re_o,
  output logic signed [DATA_W-1:0] out_im_o,
  output logic                     out_last_o
);
  localparam int HALF  = N_PTS / 2;
  localparam int NTONE = HALF - 1;
  localparam int TW    = $clog2(NTONE);
  localparam samp_t MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [1:0]    full_q, full_d;
  logic          wr_bank_q, rd_bank_q;
  logic [TW-1:0] wr_idx_q;
  logic          wr_fire, wr_end, rd_fire;
  logic          seq_last, seq_zero, seq_mirror, seq_wrap;
  logic [TW-1:0] rd_addr;
  cplx_t         wr_data, rd_data, rd_conj, out_bin;

  assign in_ready_o  = !full_q[wr_bank_q];
  assign out_valid_o = full_q[rd_bank_q];
  assign wr_fire     = in_valid_i && in_ready_o;
  assign wr_end      = wr_fire && (wr_idx_q == TW'(NTONE - 1));
  assign rd_fire     = out_valid_o && out_ready_i;
  assign wr_data     = '{re: in_re_i, im: in_im_i};

  herm_bank_store #(.DEPTH(NTONE)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .wbank_i (wr_bank_q),
    .waddr_i (wr_idx_q),
    .wdata_i (wr_data),
    .rbank_i (rd_bank_q),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  herm_bin_seq #(.N_PTS(N_PTS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (rd_fire),
    .last_o   (seq_last),
    .zero_o   (seq_zero),
    .mirror_o (seq_mirror),
    .addr_o   (rd_addr),
    .wrap_o   (seq_wrap)
  );

  herm_conj u_conj (
    .a_i (rd_data),
    .y_o (rd_conj)
  );

  always_comb begin
    if (seq_zero)        out_bin = '0;
    else if (seq_mirror) out_bin = rd_conj;
    else                 out_bin = rd_data;
  end

  assign out_re_o   = out_bin.re;
  assign out_im_o   = out_bin.im;
  assign out_last_o = seq_last;

  // write fills a bank that is never the one being drained
  always_comb begin
    full_d = full_q;
    if (wr_end)   full_d[wr_bank_q] = 1'b1;
    if (seq_wrap) full_d[rd_bank_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= '0;
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      wr_idx_q  <= '0;
    end else begin
      full_q <= full_d;
      if (wr_fire)  wr_idx_q  <= wr_end ? '0 : wr_idx_q + 1'b1;
      if (wr_end)   wr_bank_q <= ~wr_bank_q;
      if (seq_wrap) rd_bank_q <= ~rd_bank_q;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_re_o) && $stable(out_im_o) && $stable(out_last_o)));

  // R8
  drain_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && out_last_o) |=> in_ready_o);

  // R2
  dc_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && out_last_o) |=> (!out_valid_o || (out_re_o == '0 && out_im_o == '0)));

  // R6
  last_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && out_last_o) |=> !out_last_o);

  // R7
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end |=> out_valid_o);

  // R5
  no_min_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && seq_mirror) |-> (out_im_o != MIN_V));
endmodule

// File: tb/herm_frame_builder_bench.sv
module herm_frame_builder_bench;
  localparam int N    = 512;
  localparam int HALF = N / 2;
  localparam int NT   = HALF - 1;
  localparam int DW   = herm_pkg::DATA_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic signed [DW-1:0] in_re_i = '0, in_im_i = '0;
  logic in_ready_o, out_valid_o, out_last_o;
  logic signed [DW-1:0] out_re_o, out_im_o;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  herm_frame_builder #(.N_PTS(N)) u_herm_frame_builder (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_re_i, .in_im_i,
    .out_valid_o, .out_ready_i, .out_re_o, .out_im_o, .out_last_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [DW-1:0] tone_re(int s, int t);
    return DW'(s * 517 + t * 3 - 400);
  endfunction

  function automatic logic signed [DW-1:0] tone_im(int s, int t);
    if (s == 2 && t == 5) return {1'b1, {(DW-1){1'b0}}};
    return DW'(t * 7 - s * 91 - 900);
  endfunction

  task automatic send_tones(input int s, input int t0, input int t1, input int gap);
    for (int t = t0; t <= t1; t++) begin
      repeat (gap) begin @(negedge clk_i); in_valid_i = 1'b0; end
      @(negedge clk_i);
      in_valid_i = 1'b1; in_re_i = tone_re(s, t); in_im_i = tone_im(s, t);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic recv_symbol(input int s, input int mod);
    int k = 0, cnt = 0;
    logic signed [DW-1:0] er, ei;
    string req;
    bit rdy;
    while (k < N) begin
      @(negedge clk_i);
      rdy = (mod == 0) || ((cnt % mod) != 0);
      cnt++;
      out_ready_i = rdy;
      if (out_valid_o) begin
        if (k == 0 || k == HALF) begin er = '0; ei = '0; req = "R2"; end
        else if (k < HALF) begin er = tone_re(s, k - 1); ei = tone_im(s, k - 1); req = "R3"; end
        else begin
          er = tone_re(s, N - k - 1);
          if (tone_im(s, N - k - 1) == {1'b1, {(DW-1){1'b0}}}) begin
            ei = {1'b0, {(DW-1){1'b1}}}; req = "R5";
          end else begin
            ei = -tone_im(s, N - k - 1); req = "R4";
          end
        end
        if (!rdy) req = {req, "/R9 hold"};
        chk(out_re_o == er, req, $sformatf("sym %0d bin %0d re", s, k), out_re_o, er);
        chk(out_im_o == ei, req, $sformatf("sym %0d bin %0d im", s, k), out_im_o, ei);
        chk(out_last_o == (k == N - 1), "R6", $sformatf("sym %0d bin %0d last", s, k),
            out_last_o, (k == N - 1));
        @(posedge clk_i);
        if (rdy) k++;
      end else begin
        @(posedge clk_i);
      end
    end
    @(negedge clk_i);
    out_ready_i = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", "in_ready after reset", in_ready_o, 1);
    chk(out_valid_o == 1'b0, "R1", "out_valid after reset", out_valid_o, 0);
  endtask

  task automatic test_first_valid();
    send_tones(0, 0, NT - 2, 0);
    chk(out_valid_o == 1'b0, "R7", "out_valid before final tone", out_valid_o, 0);
    send_tones(0, NT - 1, NT - 1, 0);
    chk(out_valid_o == 1'b1, "R7", "out_valid after final tone", out_valid_o, 1);
    chk(in_ready_o == 1'b1, "R8", "in_ready with one symbol held", in_ready_o, 1);
  endtask

  task automatic test_both_full();
    send_tones(1, 0, NT - 1, 1);
    chk(in_ready_o == 1'b0, "R8", "in_ready with two symbols held", in_ready_o, 0);
    in_valid_i = 1'b1; in_re_i = 16'sd1234; in_im_i = 16'sd4321;
    repeat (5) @(negedge clk_i);
    chk(in_ready_o == 1'b0, "R8", "in_ready stays low under offered input", in_ready_o, 0);
    in_valid_i = 1'b0;
  endtask

  task automatic test_drain();
    recv_symbol(0, 0);
    chk(in_ready_o == 1'b1, "R8", "in_ready after drain", in_ready_o, 1);
    recv_symbol(1, 4);
    chk(out_valid_o == 1'b0, "R9", "no extra symbol after two drains", out_valid_o, 0);
  endtask

  task automatic test_overlap();
    fork
      begin send_tones(2, 0, NT - 1, 0); send_tones(3, 0, NT - 1, 2); end
      begin recv_symbol(2, 3); recv_symbol(3, 0); end
    join
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R9", "idle after overlapped run", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R8", "ready after overlapped run", in_ready_o, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_first_valid();
    test_both_full();
    test_drain();
    test_overlap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule